// File: doc/BRIEF.md
# Weighted Round-Robin Channel Arbiter

This block picks which of four DMA channels the single descriptor engine serves next. Each channel raises a request while it is enabled and has work queued. It also supplies a 3-bit weight code. The weight sets how many whole descriptors the channel may complete in one turn. The engine pulses a done strobe each time it finishes a descriptor. It holds a busy flag while a descriptor is in flight.

A turn ends in one of two ways. The first is that the granted channel has used its full descriptor quota. The second is that the channel has withdrawn its request while the engine is idle. When a turn ends, the grant passes to the next requesting channel in ascending circular order, and that channel's quota is reloaded from its weight. The grant is registered, so every decision shows at the outputs one clock after the inputs that caused it.

Top module: `wrr_dma_arbiter`

## Requirements
- R1: After reset, `grant` is 4'b0000 and `grant_vld` is low until the first clock edge that sees a request.
- R2: `grant` is zero or one-hot, with bit i standing for channel i. `grant_vld` is high exactly when `grant` is nonzero. A newly granted channel had its request high at the deciding edge.
- R3: A weight code c of 0 to 4 (channel i's code in `ch_weight[3i+2:3i]`) gives a turn of 2^c descriptors. The turn lasts for 1, 2, 4, 8 or 16 done pulses while the request stays high.
- R4: Weight codes 5, 6 and 7 give a turn of one descriptor.
- R5: At a hand-over, the search starts at the channel after the last owner and wraps from 3 to 0. After reset the search starts at channel 0. The last owner may take the grant again only when no other channel requests.
- R6: The search skips channels that are not requesting. With no requests, `grant_vld` goes low and the last-owner pointer holds.
- R7: If the granted channel drops its request while `eng_busy` is low, the grant moves at the next clock edge.
- R8: While `eng_busy` is high and no done pulse arrives, the grant does not change, even if the owner's request has dropped.
- R9: The quota reloads from the new owner's weight at every hand-over. Between hand-overs, only a done pulse changes the remaining count.
- R10: The grant outputs come from registers. They change one clock after the edge that samples the causing inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_req | input | 4 | Per-channel request: enabled and has work |
| ch_weight | input | 12 | Per-channel 3-bit weight code, channel i at bits 3i+2:3i |
| dsc_done | input | 1 | One-cycle pulse when the engine finishes a descriptor |
| eng_busy | input | 1 | Engine holds a descriptor of the granted channel in flight |
| grant | output | 4 | One-hot channel grant |
| grant_vld | output | 1 | A channel currently holds the grant |

## Verification
The bench builds the block with its default parameters: four channels and 3-bit weight codes. This covers every code, including the three reserved ones, and the longest burst of sixteen descriptors. Four channels keep the circular search short enough to reach every wrap-around and skip pattern. Random requests, weights, done pulses and busy states are mixed with directed bursts. Those bursts count done pulses per turn, drop requests with the engine idle and busy, and leave the arbiter with no requests.

// File: rtl/wrr_pkg.sv
package wrr_pkg;
  localparam int WCODE_W = 3;
  localparam int QUOTA_W = 5;

  // Descriptors allowed per turn for a weight code; reserved codes give one.
  function automatic logic [QUOTA_W-1:0] dsc_quota(input logic [WCODE_W-1:0] code);
    if (code <= 3'd4) dsc_quota = QUOTA_W'(1) << code;
    else              dsc_quota = QUOTA_W'(1);
  endfunction
endpackage

// File: rtl/wrr_pick.sv
module wrr_pick #(
  parameter int N_CH  = 4,
  localparam int IDX_W = $clog2(N_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CH-1:0]  req,
  input  logic [IDX_W-1:0] last,
  output logic [IDX_W-1:0] pick,
  output logic             found
);
  int cand;

  // Rotating priority: search starts one past the last owner, wraps, ends on it.
  always_comb begin
    found = 1'b0;
    pick  = '0;
    cand  = 0;
    for (int k = 1; k <= N_CH; k++) begin
      cand = (int'(last) + k) % N_CH;
      if (!found && req[cand[IDX_W-1:0]]) begin
        found = 1'b1;
        pick  = cand[IDX_W-1:0];
      end
    end
  end

  AST_PICK_REQUESTS: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> req[pick]); // R6
  AST_FOUND_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> found); // R6
endmodule

// File: rtl/wrr_credit.sv
module wrr_credit #(
  parameter int QW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [QW-1:0] load_val,
  input  logic          dec,
  output logic [QW-1:0] left,
  output logic          last_one
);
  always_ff @(posedge clk) begin
    if (!rst_n)    left <= '0;
    else if (load) left <= load_val;
    else if (dec)  left <= left - QW'(1);
  end

  assign last_one = (left == QW'(1));

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (left > QW'(1))); // R3
  AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val != '0)); // R4
endmodule

// File: rtl/wrr_dma_arbiter.sv
module wrr_dma_arbiter
  import wrr_pkg::*;
#(
  parameter int N_CH = 4,
  localparam int IDX_W = $clog2(N_CH),
  localparam int WV_W  = N_CH * WCODE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] ch_req,
  input  logic [WV_W-1:0] ch_weight,
  input  logic            dsc_done,
  input  logic            eng_busy,
  output logic [N_CH-1:0] grant,
  output logic            grant_vld
);
  logic [IDX_W-1:0]   own_q;
  logic               vld_q;
  logic [IDX_W-1:0]   pick_idx;
  logic               pick_found;
  logic [QUOTA_W-1:0] left;
  logic               last_dsc;

  // Named events for the assertions.
  wire own_req     = ch_req[own_q];
  wire turn_spent  = vld_q & dsc_done & last_dsc;
  wire req_gone    = vld_q & ~own_req & ~eng_busy;
  wire release_evt = turn_spent | req_gone;
  wire handover    = ~vld_q | release_evt;
  wire load_quota  = handover & pick_found;
  wire dec_quota   = ~handover & vld_q & dsc_done;

  wire [WCODE_W-1:0]  pick_code  = ch_weight[pick_idx*WCODE_W +: WCODE_W];
  wire [QUOTA_W-1:0]  pick_quota = dsc_quota(pick_code);

  wrr_pick #(.N_CH(N_CH)) u_pick (
    .clk(clk), .rst_n(rst_n), .req(ch_req), .last(own_q),
    .pick(pick_idx), .found(pick_found)
  );

  wrr_credit #(.QW(QUOTA_W)) u_credit (
    .clk(clk), .rst_n(rst_n), .load(load_quota), .load_val(pick_quota),
    .dec(dec_quota), .left(left), .last_one(last_dsc)
  );

  // Owner register: reset value makes the first search start at channel 0.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_q <= IDX_W'(N_CH - 1);
      vld_q <= 1'b0;
    end else if (handover) begin
      if (pick_found) own_q <= pick_idx;
      vld_q <= pick_found;
    end
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_grant
    assign grant[i] = vld_q & (own_q == IDX_W'(i));
  end
  assign grant_vld = vld_q;

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R2
  AST_VLD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld == (grant != '0)); // R2
  AST_HOLD_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && ((ch_req & grant) != '0) && !dsc_done) |=> $stable(grant)); // R9
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && eng_busy && !dsc_done) |=> $stable(grant)); // R8
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_req == '0 && !grant_vld) |=> !grant_vld); // R6
  AST_DROP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && ((ch_req & grant) == '0) && !eng_busy && (ch_req != '0))
      |=> !$stable(grant)); // R7
  AST_LEFT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (left != '0)); // R3
endmodule

// File: tb/test_wrr_dma_arbiter.sv
`timescale 1ns/1ps
module test_wrr_dma_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ch_req = '0;
  logic [11:0] ch_weight = '0;
  logic        dsc_done = 1'b0;
  logic        eng_busy = 1'b0;
  logic [3:0]  grant;
  logic        grant_vld;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // Reference state
  bit m_vld;
  int m_own;
  int m_left;

  always #2.5 clk = ~clk;

  wrr_dma_arbiter i_wrr_dma_arbiter (
    .clk(clk), .rst_n(rst_n), .ch_req(ch_req), .ch_weight(ch_weight),
    .dsc_done(dsc_done), .eng_busy(eng_busy), .grant(grant), .grant_vld(grant_vld)
  );

  function automatic int quota(input logic [2:0] c);
    return (c > 3'd4) ? 1 : (1 << c);
  endfunction

  function automatic logic [2:0] wcode(input logic [11:0] w, input int ch);
    return w[ch*3 +: 3];
  endfunction

  task automatic model(input logic [3:0] r, input logic [11:0] w, input bit d, input bit b);
    bit rel, hit;
    int nxt;
    rel = m_vld && ((d && m_left == 1) || (!r[m_own] && !b));
    if (!m_vld || rel) begin
      hit = 0; nxt = 0;
      for (int k = 1; k <= 4; k++) begin
        int c;
        c = (m_own + k) % 4;
        if (!hit && r[c]) begin hit = 1; nxt = c; end
      end
      if (hit) begin m_own = nxt; m_vld = 1; m_left = quota(wcode(w, nxt)); end
      else m_vld = 0;
    end else if (d) begin
      m_left = m_left - 1;
    end
  endtask

  task automatic check(input string tag);
    logic [3:0] eg;
    eg = m_vld ? 4'(1 << m_own) : 4'b0;
    checks++;
    if (grant !== eg || grant_vld !== m_vld) begin
      fails++;
      $display("FAIL %s: grant=%b vld=%b expected grant=%b vld=%b", tag, grant, grant_vld, eg, m_vld);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge after checking.
  task automatic step(input logic [3:0] r, input logic [11:0] w, input bit d, input bit b,
                      input string tag);
    ch_req = r; ch_weight = w; dsc_done = d; eng_busy = b;
    @(posedge clk);
    model(r, w, d, b);
    @(negedge clk);
    check(tag);
  endtask

  task automatic expect_int(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails + 0, checks + 0);
      $finish;
    end
  end

  initial begin
    int n;
    logic [11:0] w;
    void'($urandom(32'h5eed_1234));
    m_vld = 0; m_own = 3; m_left = 0;
    repeat (3) @(negedge clk);
    check("R1 reset state");
    rst_n = 1'b1;
    step(4'b0000, 12'h000, 0, 0, "R1 idle after reset");

    // R3: code 4 on channel 0 gives 16 descriptors; channel 1 reserved code 6
    w = 12'b000_000_110_100;
    step(4'b0011, w, 0, 0, "R5 first search starts at channel 0");
    n = 0;
    while (grant == 4'b0001 && n < 20) begin step(4'b0011, w, 1, 1, "R3 burst"); n++; end
    expect_int("R3 code 4 gives 16 descriptors", n, 16);
    expect_int("R5 moves to channel 1", grant, 4'b0010);
    n = 0;
    while (grant == 4'b0010 && n < 20) begin step(4'b0011, w, 1, 1, "R4 burst"); n++; end
    expect_int("R4 reserved code gives 1 descriptor", n, 1);
    expect_int("R9 reload wraps back to channel 0", grant, 4'b0001);

    // Codes 0..3 on channel 2 with channel 3 as competitor
    for (int c = 0; c < 4; c++) begin
      w = 12'(c) << 6;
      while (grant != 4'b0100) step(4'b1100, w, 1, 0, "R6 reach channel 2");
      n = 0;
      while (grant == 4'b0100 && n < 20) begin step(4'b1100, w, 1, 0, "R3 code burst"); n++; end
      expect_int("R3 code burst length", n, 1 << c);
    end

    // R6: no requests, pointer holds
    step(4'b0000, 12'h000, 0, 0, "R6 no requests drops valid");
    step(4'b0000, 12'h000, 1, 0, "R6 done with no owner ignored");
    step(4'b1111, 12'hfff, 0, 0, "R6 search resumes after last owner");

    // R8 / R7: drop request while busy, then busy falls
    w = 12'b011_011_011_011;
    step(4'b1111, w, 0, 0, "R10 stable grant");
    step(4'b0000 | (~grant & 4'b1111), w, 0, 1, "R8 drop while busy holds");
    step(4'b0000 | (~grant & 4'b1111), w, 0, 1, "R8 still busy holds");
    step(4'b0000 | (~grant & 4'b1111), w, 0, 0, "R7 drop with engine idle moves");
    step(grant, w, 1, 0, "R5 sole requester regains");

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] r;
      r = 4'($urandom) & 4'($urandom | 32'h3);
      step(r, 12'($urandom), ($urandom % 3) == 0, ($urandom % 4) == 0,
           "R2 R9 random stimulus");
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule